// File: doc/BRIEF.md
# Dual-Role USB Global Interrupt Status Register

This block holds the global interrupt status word of a USB controller that can run as host or as device. It sits on a simple memory-mapped register bus. Single-cycle event pulses from the protocol engine set sticky flags, and software clears each flag by writing 1 to it. The level status of the FIFOs, of the aggregated endpoint and channel interrupts and of the current role is sampled every cycle into the same word. Writes to those positions are ignored. Reserved positions always read 0.

A companion mask word at its own offset selects which status bits can raise the single interrupt line. That line is the registered OR of status AND mask, gated by a global enable. The disconnect event is honoured only in host role. A strobe from the bus fabric reports an access to a register that belongs to the other role, and that strobe latches a role-mismatch flag. When a hardware set and a software clear hit the same bit in the same cycle, the set is kept.

Top module: `usb_isr_top`

## Requirements
- R1: While reset is asserted, the status word reads 0x0400_0020 (only bits 26 and 5 set), the mask word reads 0 and `irq` is 0.
- R2: A 1 on `ev_pulse[k]` at a rising edge sets a sticky bit k, for k in {31,30,29,28,27,23,21,20,15,14,13,12,11,10,3}. The bit is visible on reads from the next cycle onward and stays set until software clears it.
- R3: A write to the status offset (0x14) clears every sticky bit (those in R2 plus bit 1) whose write-data bit is 1. Sticky bits whose write-data bit is 0 are unchanged.
- R4: If a set and a write-1 clear reach the same sticky bit at the same edge, the bit is 1 afterwards.
- R5: Bits 26, 25, 24, 19, 18, 7, 6, 5, 4 and 2 read the value that `lvl_in` held at the previous rising edge. Writes to the status offset have no effect on them.
- R6: Bit 0 reads the value `host_mode` held at the previous rising edge (1 = host, 0 = device). `lvl_in[0]` is ignored.
- R7: `ev_pulse[29]` (disconnect) sets bit 29 only when `host_mode` is 1. Bits 31, 30 and 28 are set by their pulses in either role.
- R8: A 1 on `wrong_role_acc` at a rising edge sets sticky bit 1. `ev_pulse[1]` is ignored.
- R9: Bits 22, 17, 16, 9 and 8 always read 0, whatever is pulsed or written.
- R10: The mask word at offset 0x18 holds all 32 written bits and reads them back.
- R11: `irq` equals, one rising edge later, `gie` AND the OR over all bits of (status AND mask). It is therefore 0 in the cycle after an edge at which `gie` was 0.
- R12: Reads have no wait states: while `bus_sel` is 1 and `bus_wr` is 0, `bus_rdata` shows the addressed word in the same cycle. Any other offset reads 0, and a write to any other offset changes neither word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| ev_pulse | input | 32 | Single-cycle event pulses, one per sticky bit |
| lvl_in | input | 32 | Level status inputs, one per live bit |
| host_mode | input | 1 | Current role, 1 = host |
| wrong_role_acc | input | 1 | Pulse: access to a register of the other role |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Aggregated interrupt request |

## Verification
An event pulse or a write-1 clear presented in one cycle shows on a read in the next cycle. A live level shows one edge after it is applied. `irq` follows one further edge after the status changes, and one edge after `gie` or the mask changes. The bench drives every input just after a falling edge and reads during the low phase that follows the edge of interest. Status and mask reads are combinational, so a read placed one falling edge after a stimulus observes exactly the register update due from it. `irq` is sampled one falling edge later again. Every sticky bit and every input position is swept in turn against a bench-side model built from the bit lists.

// File: rtl/usb_isr_pkg.sv
package usb_isr_pkg;
    localparam int WORD_W = 32;
    // sticky write-1-to-clear positions
    localparam logic [WORD_W-1:0] STICKY_BITS = 32'hF8B0_FC0A;
    // live read-only positions
    localparam logic [WORD_W-1:0] LIVE_BITS   = 32'h070C_00F5;
    localparam logic [WORD_W-1:0] INIT_WORD   = 32'h0400_0020;
    localparam int DISC_POS     = 29;
    localparam int MISMATCH_POS = 1;
    localparam int ROLE_POS     = 0;
endpackage

// File: rtl/isr_bit_bank.sv
module isr_bit_bank
    import usb_isr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] set_vec,
    input  logic [WORD_W-1:0] clr_vec,
    input  logic [WORD_W-1:0] live_vec,
    output logic [WORD_W-1:0] word_q
);
    logic [WORD_W-1:0] sticky_d;
    logic [WORD_W-1:0] word_d;

    always_comb begin
        // a set in the same cycle overrides a clear
        sticky_d = (word_q | set_vec) & ~(clr_vec & ~set_vec);
        word_d   = (sticky_d & STICKY_BITS) | (live_vec & LIVE_BITS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= INIT_WORD;
        else        word_q <= word_d;
    end
endmodule

// File: rtl/isr_irq_reduce.sv
module isr_irq_reduce
    import usb_isr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] sts,
    input  logic [WORD_W-1:0] mask,
    input  logic              gie,
    output logic              irq
);
    localparam logic [WORD_W-1:0] USED_BITS = STICKY_BITS | LIVE_BITS;
    logic any_hit;

    always_comb any_hit = |(sts & mask & USED_BITS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= gie & any_hit;
    end
endmodule

// File: rtl/usb_isr_top.sv
module usb_isr_top
    import usb_isr_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] STS_ADDR = 'h14,
    parameter logic [ADDR_W-1:0] MSK_ADDR = 'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [WORD_W-1:0] ev_pulse,
    input  logic [WORD_W-1:0] lvl_in,
    input  logic              host_mode,
    input  logic              wrong_role_acc,
    input  logic              gie,
    output logic              irq
);
    logic              sts_wr;
    logic              msk_wr;
    logic [WORD_W-1:0] set_vec;
    logic [WORD_W-1:0] clr_vec;
    logic [WORD_W-1:0] live_vec;
    logic [WORD_W-1:0] sts_q;
    logic [WORD_W-1:0] mask_q;

    always_comb begin
        sts_wr = bus_sel & bus_wr & (bus_addr == STS_ADDR);
        msk_wr = bus_sel & bus_wr & (bus_addr == MSK_ADDR);

        set_vec               = ev_pulse;
        set_vec[DISC_POS]     = ev_pulse[DISC_POS] & host_mode;
        set_vec[MISMATCH_POS] = wrong_role_acc;

        clr_vec  = sts_wr ? bus_wdata : '0;

        live_vec           = lvl_in;
        live_vec[ROLE_POS] = host_mode;
    end

    isr_bit_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .live_vec (live_vec),
        .word_q   (sts_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mask_q <= '0;
        else if (msk_wr) mask_q <= bus_wdata;
    end

    isr_irq_reduce u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .sts   (sts_q),
        .mask  (mask_q),
        .gie   (gie),
        .irq   (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (1'b1)
                (bus_addr == STS_ADDR): bus_rdata = sts_q;
                (bus_addr == MSK_ADDR): bus_rdata = mask_q;
                default:                bus_rdata = '0;
            endcase
        end
    end
endmodule

module usb_isr_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] STS_ADDR = 'h14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [31:0]       ev_pulse,
    input logic [31:0]       lvl_in,
    input logic              host_mode,
    input logic              wrong_role_acc,
    input logic              gie,
    input logic              irq,
    input logic [31:0]       sts_q,
    input logic [31:0]       mask_q
);
    logic sts_wr;
    assign sts_wr = bus_sel && bus_wr && (bus_addr == STS_ADDR);

    a_r2_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pulse[30] |=> sts_q[30]);

    a_r3_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && bus_wdata[13] && !ev_pulse[13]) |=> !sts_q[13]);

    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && bus_wdata[12] && ev_pulse[12]) |=> sts_q[12]);

    a_r5_live_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sts_q[19] == $past(lvl_in[19])));

    a_r6_role_bit: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sts_q[0] == $past(host_mode)));

    a_r7_disc_host_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!sts_q[29] && !(host_mode && ev_pulse[29])) |=> !sts_q[29]);

    a_r8_mismatch_set: assert property (@(posedge clk) disable iff (!rst_n)
        wrong_role_acc |=> sts_q[1]);

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |-> ((bus_rdata & 32'h0043_0300) == 32'h0));

    a_r11_gie_low: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |=> !irq);

    a_r11_irq_track: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(gie && ((sts_q & mask_q) != 32'h0))));
endmodule

bind usb_isr_top usb_isr_chk #(.ADDR_W(ADDR_W), .STS_ADDR(STS_ADDR)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_sel        (bus_sel),
    .bus_wr         (bus_wr),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .ev_pulse       (ev_pulse),
    .lvl_in         (lvl_in),
    .host_mode      (host_mode),
    .wrong_role_acc (wrong_role_acc),
    .gie            (gie),
    .irq            (irq),
    .sts_q          (sts_q),
    .mask_q         (mask_q)
);

// File: tb/usb_isr_top_tb.sv
`timescale 1ns/1ps
module usb_isr_top_tb;
    localparam logic [31:0] STK  = 32'hF8B0_FC0A;
    localparam logic [31:0] LIV  = 32'h070C_00F5;
    localparam logic [7:0]  A_ST = 8'h14;
    localparam logic [7:0]  A_MK = 8'h18;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [31:0] ev_pulse, lvl_in;
    logic        host_mode, wrong_role_acc, gie, irq;

    int total = 0;
    int fails = 0;
    logic [31:0] exp_stk;
    logic [31:0] rv;

    always #5 clk = ~clk;

    usb_isr_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_pulse(ev_pulse), .lvl_in(lvl_in), .host_mode(host_mode),
        .wrong_role_acc(wrong_role_acc), .gie(gie), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic pulse(input logic [31:0] v);
        ev_pulse = v;
        @(negedge clk);
        ev_pulse = '0;
    endtask

    function automatic logic [31:0] model();
        return exp_stk | (lvl_in & LIV & 32'hFFFF_FFFE) | {31'b0, host_mode};
    endfunction

    task automatic chk_sts(input string tag);
        logic [31:0] d;
        rd(A_ST, d);
        chk(tag, d, model());
    endtask

    initial begin
        #1_000_000;
        fails++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        ev_pulse = 0; lvl_in = 0; host_mode = 0; wrong_role_acc = 0; gie = 0;
        exp_stk = 0;
        repeat (3) @(negedge clk);
        rd(A_ST, rv); chk("R1 status reset", rv, 32'h0400_0020);
        rd(A_MK, rv); chk("R1 mask reset", rv, 32'h0);
        chk("R1 irq reset", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_sts("R5 live bits follow zero inputs after reset");
        host_mode = 1'b1;
        @(negedge clk);
        chk_sts("R6 host role bit");

        // sticky sweep
        for (int i = 0; i < 32; i++) begin
            if (STK[i] && i != 1) begin
                pulse(32'h1 << i);
                exp_stk[i] = 1'b1;
                chk_sts($sformatf("R2 set bit %0d", i));
                wr(A_ST, 32'h0);
                chk_sts($sformatf("R3 write 0 keeps bit %0d", i));
                wr(A_ST, 32'h1 << i);
                exp_stk[i] = 1'b0;
                chk_sts($sformatf("R3 write 1 clears bit %0d", i));
            end
        end

        // live sweep
        for (int i = 0; i < 32; i++) begin
            lvl_in = 32'h1 << i;
            @(negedge clk);
            chk_sts($sformatf("R5 live input %0d", i));
            wr(A_ST, 32'hFFFF_FFFF);
            chk_sts($sformatf("R5 write ignored at input %0d", i));
        end
        lvl_in = 32'h0;
        @(negedge clk);

        // reserved positions
        pulse(32'h0043_0300);
        chk_sts("R9 reserved pulses read 0");
        pulse(32'hFFFF_FFFF);
        exp_stk = STK & 32'hFFFF_FFFD;
        chk_sts("R9 all pulses, reserved still 0");
        wr(A_ST, 32'hFFFF_FFFF);
        exp_stk = 0;
        chk_sts("R3 clear all");

        // role gating
        host_mode = 1'b0;
        @(negedge clk);
        pulse(32'hF000_0000);
        exp_stk = 32'hD000_0000;
        chk_sts("R7 device role: disconnect dropped");
        host_mode = 1'b1;
        @(negedge clk);
        pulse(32'h2000_0000);
        exp_stk[29] = 1'b1;
        chk_sts("R7 host role: disconnect latched");
        wr(A_ST, 32'hFFFF_FFFF);
        exp_stk = 0;

        // role mismatch
        pulse(32'h0000_0002);
        chk_sts("R8 ev_pulse bit 1 ignored");
        wrong_role_acc = 1'b1;
        @(negedge clk);
        wrong_role_acc = 1'b0;
        exp_stk[1] = 1'b1;
        chk_sts("R8 mismatch latched");
        wr(A_ST, 32'h2);
        exp_stk[1] = 1'b0;
        chk_sts("R8 mismatch cleared");

        // set beats clear
        for (int k = 0; k < 2; k++) begin
            ev_pulse = 32'h800;
            bus_sel = 1; bus_wr = 1; bus_addr = A_ST; bus_wdata = 32'h800;
            @(negedge clk);
            ev_pulse = 0; bus_sel = 0; bus_wr = 0; bus_wdata = 0;
            exp_stk[11] = 1'b1;
            chk_sts($sformatf("R4 set wins pass %0d", k));
        end
        wr(A_ST, 32'h800);
        exp_stk[11] = 1'b0;
        chk_sts("R3 clear after set-wins");

        // mask and decode
        wr(A_MK, 32'hA5A5_5A5A);
        rd(A_MK, rv); chk("R10 mask readback", rv, 32'hA5A5_5A5A);
        rd(8'h20, rv); chk("R12 unmapped read 0", rv, 32'h0);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(A_MK, rv); chk("R12 stray write mask", rv, 32'hA5A5_5A5A);
        chk_sts("R12 stray write status");

        // interrupt line
        wr(A_MK, 32'h8);
        gie = 1'b1;
        @(negedge clk);
        chk("R11 irq idle", {31'b0, irq}, 32'h0);
        ev_pulse = 32'h8;
        @(negedge clk);
        ev_pulse = 0;
        exp_stk[3] = 1'b1;
        chk("R11 irq not yet", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R11 irq raised", {31'b0, irq}, 32'h1);
        gie = 1'b0;
        @(negedge clk);
        chk("R11 irq gated by gie", {31'b0, irq}, 32'h0);
        gie = 1'b1;
        @(negedge clk);
        chk("R11 irq back", {31'b0, irq}, 32'h1);
        wr(A_MK, 32'h0);
        @(negedge clk);
        chk("R11 irq masked", {31'b0, irq}, 32'h0);
        wr(A_ST, 32'h8);
        exp_stk[3] = 1'b0;
        chk_sts("R3 final clear");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule